// File: doc/BRIEF.md
# Timed Signature Compactor for Paired Data Paths

This block compacts the traffic on two parallel data paths, an I path and a Q path, into one 16-bit signature per path. Self-test logic then compares each signature with a known-good value. Each path receives a 24-bit word together with a shared valid strobe. A single control word arms the block. Its low 15 bits set how many valid words are folded in. Its top bit selects one of two modes: pseudorandom compaction, or a capture mode that simply holds the most recent raw input.

Writing the control word resets both signatures to all ones and loads the countdown. Each later cycle in which the strobe is high updates both signatures and takes one from the count. When the count runs out, the block raises `done`. It then ignores all data until the next write. The block also raises `done` straight away when the loaded count is zero.

A three-state controller sequences the block:

- **IDLE** is the state after reset.
- **RUN** is the state in which compaction takes place.
- **FIN** is the state in which the count has run out and the signatures are frozen.

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| arm | IDLE or FIN | RUN | Write with a nonzero count |
| rearm | RUN | RUN | Write with a nonzero count |
| arm_empty | any state | FIN | Write with a zero count |
| expire | RUN | FIN | The last counted valid cycle |

Top module: `bist_sig_top`

## Requirements
- R1: While reset is asserted, and directly after it, both signatures read 0xFFFF and `done` is low.
- R2: A control write sets both signatures to 0xFFFF on the next clock edge and loads the count from `ctl_word[14:0]`. After that edge, `done` is high exactly when that count is zero.
- R3: With `ctl_word[15]`=0, each update first folds the 24-bit input as `d[15:0] ^ {8'h00, d[23:16]}`. It then computes `sig' = ({sig[14:0],1'b0} ^ (sig[15] ? 16'h100B : 0)) ^ folded`, where 0x100B encodes x^16+x^12+x^3+x+1.
- R4: With `ctl_word[15]`=1, each update loads `d[15:0]` directly into the signature.
- R5: A signature updates only on a cycle in which the block is counting and `in_vld` is high. Each such cycle lowers the count by one, and cycles with `in_vld` low change neither the signatures nor the count.
- R6: `done` rises right after the N-th counted valid cycle, where N is the loaded count. It then stays high, and the signatures stay frozen, until the next control write.
- R7: A write with a zero count leaves the signatures at 0xFFFF and ignores any later valid data.
- R8: A write during a run restarts the block. A write in the same cycle as a valid word takes priority, so that word is not folded in.
- R9: The I and Q signatures are computed independently, each from its own input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | 16 | Bit 15 is the mode (1 = direct load); bits 14:0 are the count |
| in_vld | input | 1 | Valid strobe shared by both data paths |
| i_data | input | 24 | I path input word |
| q_data | input | 24 | Q path input word |
| i_sig | output | 16 | I path signature |
| q_sig | output | 16 | Q path signature |
| done | output | 1 | The count has run out |

## Verification
The bench builds the block with its default parameters: 24-bit data, 16-bit signatures and a 15-bit count. With these values the fold actually mixes the upper byte into the lower one, and the polynomial taps are exercised. The counts in the bench range from zero up to 256. These values reach several cases:

- the immediate-finish case;
- runs where the strobe has gaps;
- runs driven well past expiry;
- restarts partway through a run;
- writes that collide with valid data.

Two hand-computed single-step signatures pin down the fold and the direct-load mode independently of the bench's reference function.

// File: rtl/bist_sig_pkg.sv
package bist_sig_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } bist_state_e;

    localparam int DEF_DATA_W = 24;
    localparam int DEF_SIG_W  = 16;
    localparam int DEF_TMR_W  = 15;
    localparam int NUM_LANES  = 2;

endpackage

// File: rtl/bist_sig_tmr.sv
module bist_sig_tmr #(
    parameter int TMR_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             dec,
    output logic             load_zero,
    output logic             last
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign load_zero = (load_val == '0);
    assign last      = (cnt_q == ONE);
endmodule

// File: rtl/bist_sig_fsm.sv
module bist_sig_fsm
    import bist_sig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_mode,
    input  logic load_zero,
    input  logic tmr_last,
    input  logic in_vld,
    output logic lane_clr,
    output logic lane_en,
    output logic direct,
    output logic tmr_load,
    output logic tmr_dec,
    output logic done
);
    bist_state_e state_q, state_d;
    logic        mode_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Mode latched on each control write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (ctl_wr) begin
            mode_q <= ctl_mode;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                if (ctl_wr) begin
                    state_d = load_zero ? ST_FIN : ST_RUN;   // arm / arm_empty
                end
            end
            ST_RUN: begin
                if (ctl_wr) begin
                    state_d = load_zero ? ST_FIN : ST_RUN;   // rearm / arm_empty
                end else if (in_vld && tmr_last) begin
                    state_d = ST_FIN;                        // expire
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        lane_clr = ctl_wr;
        tmr_load = ctl_wr;
        direct   = mode_q;
        lane_en  = 1'b0;
        tmr_dec  = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                lane_en = in_vld && !ctl_wr;
                tmr_dec = in_vld && !ctl_wr;
            end
            ST_FIN: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bist_sig_lane.sv
module bist_sig_lane #(
    parameter int                DATA_W = 24,
    parameter int                SIG_W  = 16,
    parameter logic [SIG_W-1:0]  POLY   = 16'h100B,
    parameter logic [SIG_W-1:0]  SEED   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              direct,
    input  logic [DATA_W-1:0] din,
    output logic [SIG_W-1:0]  sig
);
    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] folded;
    logic [SIG_W-1:0] shifted;
    logic [SIG_W-1:0] sig_d;

    // Fold the input word onto the signature width by XOR
    always_comb begin
        folded = '0;
        for (int b = 0; b < DATA_W; b++) begin
            folded[b % SIG_W] = folded[b % SIG_W] ^ din[b];
        end
    end

    // Galois shift with feedback taps
    always_comb begin
        shifted = {sig_q[SIG_W-2:0], 1'b0};
        if (sig_q[SIG_W-1]) begin
            shifted = shifted ^ POLY;
        end
    end

    assign sig_d = direct ? din[SIG_W-1:0] : (shifted ^ folded);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= SEED;
        end else if (clr) begin
            sig_q <= SEED;
        end else if (en) begin
            sig_q <= sig_d;
        end
    end

    assign sig = sig_q;
endmodule

// File: rtl/bist_sig_top.sv
module bist_sig_top
    import bist_sig_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int SIG_W  = DEF_SIG_W,
    parameter int TMR_W  = DEF_TMR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [TMR_W:0]    ctl_word,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] i_data,
    input  logic [DATA_W-1:0] q_data,
    output logic [SIG_W-1:0]  i_sig,
    output logic [SIG_W-1:0]  q_sig,
    output logic              done
);
    localparam int MODE_BIT = TMR_W;

    logic lane_clr, lane_en, direct, tmr_load, tmr_dec;
    logic load_zero, tmr_last;

    logic [DATA_W-1:0] lane_din [NUM_LANES];
    logic [SIG_W-1:0]  lane_sig [NUM_LANES];

    assign lane_din[0] = i_data;
    assign lane_din[1] = q_data;

    bist_sig_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_mode  (ctl_word[MODE_BIT]),
        .load_zero (load_zero),
        .tmr_last  (tmr_last),
        .in_vld    (in_vld),
        .lane_clr  (lane_clr),
        .lane_en   (lane_en),
        .direct    (direct),
        .tmr_load  (tmr_load),
        .tmr_dec   (tmr_dec),
        .done      (done)
    );

    bist_sig_tmr #(.TMR_W(TMR_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .load_val  (ctl_word[TMR_W-1:0]),
        .dec       (tmr_dec),
        .load_zero (load_zero),
        .last      (tmr_last)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        bist_sig_lane #(
            .DATA_W (DATA_W),
            .SIG_W  (SIG_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (lane_clr),
            .en     (lane_en),
            .direct (direct),
            .din    (lane_din[g]),
            .sig    (lane_sig[g])
        );
    end

    assign i_sig = lane_sig[0];
    assign q_sig = lane_sig[1];
endmodule

// File: rtl/bist_sig_chk.sv
module bist_sig_chk #(
    parameter int SIG_W = 16,
    parameter int TMR_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [TMR_W:0]   ctl_word,
    input logic             in_vld,
    input logic [SIG_W-1:0] i_lo,
    input logic [SIG_W-1:0] i_sig,
    input logic [SIG_W-1:0] q_sig,
    input logic             done
);
    logic armed_q, mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            mode_q  <= 1'b0;
        end else if (ctl_wr) begin
            armed_q <= 1'b1;
            mode_q  <= ctl_word[TMR_W];
        end
    end

    // R1
    reset_seed_chk: assert property (@(posedge clk)
        !rst_n |=> (i_sig == '1 && q_sig == '1 && !done));

    // R2
    write_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (i_sig == '1 && q_sig == '1));

    // R2
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (done == ($past(ctl_word[TMR_W-1:0]) == '0)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && !ctl_wr) |=> ($stable(i_sig) && $stable(q_sig)));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ctl_wr) |=> (done && $stable(i_sig) && $stable(q_sig)));

    // R4
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && mode_q && in_vld && !done && !ctl_wr) |=> (i_sig == $past(i_lo)));
endmodule

bind bist_sig_top bist_sig_chk #(.SIG_W(SIG_W), .TMR_W(TMR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_word (ctl_word),
    .in_vld   (in_vld),
    .i_lo     (i_data[SIG_W-1:0]),
    .i_sig    (i_sig),
    .q_sig    (q_sig),
    .done     (done)
);

// File: tb/bist_sig_top_test.sv
module bist_sig_top_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] ctl;
        logic [9:0]  ncyc;
        logic [3:0]  gap;
        logic [23:0] seed;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{16'h0005, 10'd5,   4'd0, 24'h123456},
        '{16'h0008, 10'd30,  4'd1, 24'hABCDEF},
        '{16'h8003, 10'd3,   4'd0, 24'hFF00FF},
        '{16'h8004, 10'd20,  4'd2, 24'h00A5A5},
        '{16'h0001, 10'd4,   4'd0, 24'hFFFFFF},
        '{16'h0040, 10'd90,  4'd0, 24'h800001},
        '{16'h0100, 10'd600, 4'd1, 24'h3C3C3C}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_word = '0;
    logic        in_vld = 1'b0;
    logic [23:0] i_data = '0;
    logic [23:0] q_data = '0;
    logic [15:0] i_sig, q_sig;
    logic        done;

    int checks = 0;
    int fails  = 0;

    // Reference state
    logic [15:0] m_i = 16'hFFFF, m_q = 16'hFFFF;
    logic [14:0] m_cnt = '0;
    logic        m_mode = 1'b0, m_run = 1'b0, m_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bist_sig_top uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
        .in_vld(in_vld), .i_data(i_data), .q_data(q_data),
        .i_sig(i_sig), .q_sig(q_sig), .done(done)
    );

    function automatic logic [15:0] ref_next(logic [15:0] s, logic [23:0] d, logic dir);
        logic [15:0] t;
        if (dir) return d[15:0];
        t = {s[14:0], 1'b0};
        if (s[15]) t = t ^ 16'h100B;
        return t ^ d[15:0] ^ {8'h00, d[23:16]};
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(i_sig, m_i, {req, " i_sig"});
        chk(q_sig, m_q, {req, " q_sig"});
        chk({15'd0, done}, {15'd0, m_done}, {req, " done"});
    endtask

    // Drive at negedge, update model at posedge, return at next negedge
    task automatic step(input logic wr, input logic [15:0] cw, input logic vld,
                        input logic [23:0] di, input logic [23:0] dq);
        ctl_wr = wr; ctl_word = cw; in_vld = vld; i_data = di; q_data = dq;
        @(posedge clk);
        if (wr) begin
            m_i = 16'hFFFF; m_q = 16'hFFFF;
            m_cnt = cw[14:0]; m_mode = cw[15];
            m_done = (cw[14:0] == 15'd0); m_run = !m_done;
        end else if (m_run && vld) begin
            m_i = ref_next(m_i, di, m_mode);
            m_q = ref_next(m_q, dq, m_mode);
            m_cnt = m_cnt - 15'd1;
            if (m_cnt == 15'd0) begin m_run = 1'b0; m_done = 1'b1; end
        end
        @(negedge clk);
        ctl_wr = 1'b0; in_vld = 1'b0;
    endtask

    function automatic logic [23:0] pat_i(logic [23:0] seed, int k);
        return seed ^ (24'(k) * 24'h01F3A7);
    endfunction

    function automatic logic [23:0] pat_q(logic [23:0] seed, int k);
        logic [23:0] a;
        a = pat_i(seed, k);
        return {a[11:0], a[23:12]} ^ 24'h5A5A5A;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(i_sig, 16'hFFFF, "R1 i_sig in reset");
        chk(q_sig, 16'hFFFF, "R1 q_sig in reset");
        chk({15'd0, done}, 16'd0, "R1 done in reset");
        rst_n = 1'b1;
        step(1'b0, 16'h0000, 1'b1, 24'h111111, 24'h222222);
        chk_all("R1 after reset, idle ignores data");

        // Table walk: R3 R4 R5 R6 R9
        for (int v = 0; v < 7; v++) begin
            step(1'b1, VEC[v].ctl, 1'b0, '0, '0);
            chk_all("R2 after write");
            for (int k = 0; k < int'(VEC[v].ncyc); k++) begin
                step(1'b0, 16'h0000, (k % (int'(VEC[v].gap) + 1)) == 0,
                     pat_i(VEC[v].seed, k), pat_q(VEC[v].seed, k));
            end
            chk_all(VEC[v].ctl[15] ? "R4 R6 R9 direct run" : "R3 R5 R6 R9 compact run");
        end

        // R3 hand-computed fold: FFFF, data FF0000 -> EF0A; zero data -> EFF5
        step(1'b1, 16'h0002, 1'b0, '0, '0);
        step(1'b0, 16'h0000, 1'b1, 24'hFF0000, 24'h000000);
        chk(i_sig, 16'hEF0A, "R3 fold i_sig");
        chk(q_sig, 16'hEFF5, "R3 shift q_sig");
        chk({15'd0, done}, 16'd0, "R6 not done after 1 of 2");

        // R4 hand-computed direct load
        step(1'b1, 16'h8001, 1'b0, '0, '0);
        step(1'b0, 16'h0000, 1'b1, 24'hABCDEF, 24'h123456);
        chk(i_sig, 16'hCDEF, "R4 direct i_sig");
        chk(q_sig, 16'h3456, "R4 direct q_sig");
        chk({15'd0, done}, 16'd1, "R6 done after 1 of 1");

        // R7 zero count
        step(1'b1, 16'h0000, 1'b0, '0, '0);
        chk_all("R7 zero count write");
        for (int k = 0; k < 4; k++) step(1'b0, 16'h0000, 1'b1, pat_i(24'h77, k), pat_q(24'h77, k));
        chk_all("R7 data ignored after zero count");

        // R5 gaps do not count
        step(1'b1, 16'h0003, 1'b0, '0, '0);
        step(1'b0, 16'h0000, 1'b1, 24'h010203, 24'h040506);
        step(1'b0, 16'h0000, 1'b1, 24'h0A0B0C, 24'h0D0E0F);
        for (int k = 0; k < 5; k++) step(1'b0, 16'h0000, 1'b0, 24'hFFFFFF, 24'hFFFFFF);
        chk({15'd0, done}, 16'd0, "R5 idle cycles do not count");
        chk_all("R5 signatures held over gap");
        step(1'b0, 16'h0000, 1'b1, 24'h102030, 24'h405060);
        chk({15'd0, done}, 16'd1, "R5 R6 done after third valid");

        // R8 restart mid-run, write colliding with valid data
        step(1'b1, 16'h0010, 1'b0, '0, '0);
        for (int k = 0; k < 4; k++) step(1'b0, 16'h0000, 1'b1, pat_i(24'h99, k), pat_q(24'h99, k));
        step(1'b1, 16'h0002, 1'b1, 24'hDEADBE, 24'hEFCAFE);
        chk(i_sig, 16'hFFFF, "R8 write wins over valid i_sig");
        chk(q_sig, 16'hFFFF, "R8 write wins over valid q_sig");
        chk({15'd0, done}, 16'd0, "R8 restart clears done");
        step(1'b0, 16'h0000, 1'b1, 24'h135790, 24'h246801);
        step(1'b0, 16'h0000, 1'b1, 24'hFEDCBA, 24'h987654);
        chk_all("R8 R6 restarted run completes");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule